// File: doc/BRIEF.md
# Capture-Restart Interval Timer

A 16-bit up-counting timer that measures the spacing of edges on an external input. The counter advances on every prescaler tick while the timer is enabled. When an edge of the selected polarity arrives on the timer input, the running count is copied into a capture register, the counter restarts at 0001H, a cause flag is set and a one-cycle interrupt pulse is raised. If no edge arrives, the counter climbs to a programmable reload value, restarts at 0001H, clears the cause flag and raises the same interrupt.

Software tells the two interrupt causes apart in one of two ways. It can read the cause flag, or it can clear the capture register to 0000H before starting and check whether the register is still zero after the interrupt. All configuration and readback goes through a byte-wide register port with separate write and read addresses.

Top module: `capt_timer`

## Requirements
- R1: After reset every register address reads 00H and `irq` is low.
- R2: While enabled, the count rises by one on each prescaler tick. A prescale field value p (0..7) gives one tick every 2^p clock cycles. The prescaler restarts from zero when the timer is disabled and on every capture.
- R3: The timer input passes through a two-stage synchroniser. An input change made before clock edge k is captured at edge k+2. The capture register receives the count held just before that edge.
- R4: Control bit 6 selects the capture edge: 1 selects a rising edge and 0 a falling edge. An edge of the other polarity leaves the count, the flag and the capture register untouched.
- R5: On a capture the counter restarts at 0001H and the cause flag is set. `irq` is high for exactly the one cycle after the capture edge.
- R6: When a tick occurs while the count equals the reload value and no capture is taken, the counter restarts at 0001H and the cause flag clears. `irq` pulses for one cycle and the capture register keeps its value. Starting from 0001H, interrupts therefore recur every reload-value ticks.
- R7: If a capture and a reload match fall in the same cycle, only the capture takes effect. The flag is set, the captured value is the count, and a single interrupt is raised.
- R8: While control bit 7 (enable) is low, the count holds, input edges are ignored and no interrupt is raised.
- R9: The register map is as follows. Address 0 is control: bit 7 enable, bit 6 edge select, bits 2:0 prescale, other bits read 0. Address 1 bit 0 is the cause flag, which is read-only. Addresses 2 and 3 are the count high and low bytes, 4 and 5 the reload high and low bytes, and 6 and 7 the capture high and low bytes. All registers except address 1 are writable byte by byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| timerIn | input | 1 | External timer input, asynchronous |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench applies rising edges with no prescaling, where the captured value pins down the synchroniser latency. It applies falling edges with divide-by-four, where an interleaved rising edge must be ignored and the second capture shows that the prescaler restarted. Free-running reload periods at two prescale settings separate the match-and-restart timing from the tick rate. A capture timed to land exactly on a reload match separates the priority rule from a double interrupt. Toggling the input while the timer is disabled, and then reading the count and flag back, shows that nothing moved.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_REL_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_REL_LO = 3'd5;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd6;
  localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd7;

  localparam logic [CNT_W-1:0] RESTART_VAL = 16'h0001;

  typedef struct packed {
    logic tick;
    logic capture;
    logic restart;
  } tmrStb_t;
endpackage

// File: rtl/ct_ctrl.sv
module ct_ctrl
  import ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              timerIn,
  input  logic              cntAtReload,
  output tmrStb_t           stb,
  output logic [DATA_W-1:0] ctrlByte,
  output logic              timerEn,
  output logic              irq
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic             enReg;
  logic             polReg;
  logic [PRE_W-1:0] preSel;
  logic [DIV_W-1:0] preCnt;
  logic [DIV_W-1:0] divMask;
  logic [SYNC_STAGES-1:0] syncQ;
  logic             prevQ;
  logic             syncNow;
  logic             riseHit;
  logic             fallHit;
  logic             edgeHit;
  logic             tickNow;

  // control register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg  <= 1'b0;
      polReg <= 1'b0;
      preSel <= '0;
    end else if (wrEn && wrAddr == A_CTRL) begin
      enReg  <= wrData[7];
      polReg <= wrData[6];
      preSel <= wrData[PRE_W-1:0];
    end
  end

  // input synchroniser chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else if (s == 0) syncQ[s] <= timerIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else prevQ <= syncNow;
  end

  assign riseHit = syncNow & ~prevQ;
  assign fallHit = ~syncNow & prevQ;
  assign edgeHit = polReg ? riseHit : fallHit;

  // prescaler: mask with the low preSel bits set
  generate
    for (genvar b = 0; b < DIV_W; b++) begin : g_mask
      assign divMask[b] = (b < int'(preSel));
    end
  endgenerate

  assign tickNow = enReg && ((preCnt & divMask) == divMask);

  always_comb begin
    stb.tick    = tickNow;
    stb.capture = enReg & edgeHit;
    stb.restart = tickNow & cntAtReload & ~(enReg & edgeHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else if (!enReg || stb.capture) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else irq <= stb.capture | stb.restart;
  end

  always_comb begin
    ctrlByte = '0;
    ctrlByte[7] = enReg;
    ctrlByte[6] = polReg;
    ctrlByte[PRE_W-1:0] = preSel;
  end

  assign timerEn = enReg;
endmodule

// File: rtl/ct_datapath.sv
module ct_datapath
  import ct_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] ctrlByte,
  input  tmrStb_t           stb,
  output logic [DATA_W-1:0] rdData,
  output logic              cntAtReload,
  output logic [CNT_W-1:0]  cntVal,
  output logic [CNT_W-1:0]  captVal,
  output logic              capFlag
);
  localparam int HI_LSB = CNT_W - DATA_W;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] relQ;
  logic [CNT_W-1:0] capQ;
  logic             flagQ;
  logic             wrCntHi, wrCntLo, wrCapHi, wrCapLo;

  assign wrCntHi = wrEn && wrAddr == A_CNT_HI;
  assign wrCntLo = wrEn && wrAddr == A_CNT_LO;
  assign wrCapHi = wrEn && wrAddr == A_CAP_HI;
  assign wrCapLo = wrEn && wrAddr == A_CAP_LO;

  // counter: software write beats hardware update
  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else if (wrCntHi) cntQ[CNT_W-1:HI_LSB] <= wrData;
    else if (wrCntLo) cntQ[DATA_W-1:0] <= wrData;
    else if (stb.capture || stb.restart) cntQ <= RESTART_VAL;
    else if (stb.tick) cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) relQ <= '0;
    else if (wrEn && wrAddr == A_REL_HI) relQ[CNT_W-1:HI_LSB] <= wrData;
    else if (wrEn && wrAddr == A_REL_LO) relQ[DATA_W-1:0] <= wrData;
  end

  // capture register: hardware capture beats software write
  always_ff @(posedge clk) begin
    if (!rstN) capQ <= '0;
    else if (stb.capture) capQ <= cntQ;
    else if (wrCapHi) capQ[CNT_W-1:HI_LSB] <= wrData;
    else if (wrCapLo) capQ[DATA_W-1:0] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= 1'b0;
    else if (stb.capture) flagQ <= 1'b1;
    else if (stb.restart) flagQ <= 1'b0;
  end

  assign cntAtReload = (cntQ == relQ);

  always_comb begin
    unique case (rdAddr)
      A_CTRL:   rdData = ctrlByte;
      A_STAT:   rdData = {{(DATA_W-1){1'b0}}, flagQ};
      A_CNT_HI: rdData = cntQ[CNT_W-1:HI_LSB];
      A_CNT_LO: rdData = cntQ[DATA_W-1:0];
      A_REL_HI: rdData = relQ[CNT_W-1:HI_LSB];
      A_REL_LO: rdData = relQ[DATA_W-1:0];
      A_CAP_HI: rdData = capQ[CNT_W-1:HI_LSB];
      A_CAP_LO: rdData = capQ[DATA_W-1:0];
      default:  rdData = '0;
    endcase
  end

  assign cntVal  = cntQ;
  assign captVal = capQ;
  assign capFlag = flagQ;
endmodule

// File: rtl/capt_timer.sv
module capt_timer
  import ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic [2:0]  rdAddr,
  output logic [7:0]  rdData,
  input  logic        timerIn,
  output logic        irq
);
  tmrStb_t          stb;
  logic [7:0]       ctrlByte;
  logic             timerEn;
  logic             cntAtReload;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] captVal;
  logic             capFlag;

  ct_ctrl #(.SYNC_STAGES(SYNC_STAGES), .PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timerIn(timerIn), .cntAtReload(cntAtReload), .stb(stb),
    .ctrlByte(ctrlByte), .timerEn(timerEn), .irq(irq)
  );

  ct_datapath u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .ctrlByte(ctrlByte), .stb(stb), .rdData(rdData),
    .cntAtReload(cntAtReload), .cntVal(cntVal), .captVal(captVal),
    .capFlag(capFlag)
  );
endmodule

// File: rtl/capt_timer_chk.sv
module capt_timer_chk
  import ct_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [2:0]       wrAddr,
  input logic             irq,
  input tmrStb_t          stb,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] captVal,
  input logic             capFlag,
  input logic             timerEn
);
  logic cntWrite, captWrite;
  assign cntWrite  = wrEn && (wrAddr == A_CNT_HI || wrAddr == A_CNT_LO);
  assign captWrite = wrEn && (wrAddr == A_CAP_HI || wrAddr == A_CAP_LO);

  // R3
  capture_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> captVal == $past(cntVal));

  // R5
  capture_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && !cntWrite) |=> (cntVal == RESTART_VAL && capFlag));

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture || stb.restart) |=> irq);

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.capture || stb.restart) |=> !irq);

  // R6
  reload_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.restart && !cntWrite) |=> (cntVal == RESTART_VAL && !capFlag));

  // R6
  reload_keeps_capt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.restart && !captWrite) |=> $stable(captVal));

  // R7
  single_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.capture, stb.restart}));

  // R8
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!timerEn && !cntWrite) |=> $stable(cntVal));

  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !timerEn |-> !(stb.capture || stb.restart || stb.tick));
endmodule

bind capt_timer capt_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .irq(irq),
  .stb(stb), .cntVal(cntVal), .captVal(captVal), .capFlag(capFlag),
  .timerEn(timerEn)
);

// File: tb/tb_capt_timer.sv
`timescale 1ns/1ps
module tb_capt_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr;
  logic [7:0] rdData;
  logic       timerIn = 1'b0;
  logic       irq;

  logic [2:0] drvAddr = '0;
  logic [2:0] monAddr = '0;
  logic       monBusy = 1'b0;
  assign rdAddr = monBusy ? monAddr : drvAddr;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          cyc;
    logic        flag;
    logic [15:0] capt;
    string       req;
  } expItem_t;
  expItem_t expQ[$];

  capt_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .timerIn(timerIn), .irq(irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(logic [2:0] a, logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd8(logic [2:0] a, output logic [7:0] v);
    drvAddr = a; #0.1; v = rdData;
  endtask

  task automatic rd16(logic [2:0] aHi, output logic [15:0] v);
    logic [7:0] h, l;
    rd8(aHi, h); rd8(aHi + 3'd1, l);
    v = {h, l};
  endtask

  task automatic expectIrq(int c, logic f, logic [15:0] cv, string req);
    expItem_t e;
    e.cyc = c; e.flag = f; e.capt = cv; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic setup(logic [15:0] cnt, logic [15:0] rel, logic [15:0] cap);
    wr(3'd0, 8'h00);
    wr(3'd2, cnt[15:8]); wr(3'd3, cnt[7:0]);
    wr(3'd4, rel[15:8]); wr(3'd5, rel[7:0]);
    wr(3'd6, cap[15:8]); wr(3'd7, cap[7:0]);
  endtask

  // monitor: pops an expected item for every interrupt pulse
  always @(negedge clk) begin
    if (rstN && irq) begin
      if (expQ.size() == 0) begin
        chk("R8", "unexpected interrupt at cycle", 16'(cyc), 16'hFFFF);
      end else begin
        expItem_t e;
        logic [7:0] h, l, s;
        e = expQ.pop_front();
        monBusy = 1'b1;
        monAddr = 3'd6; #0.1; h = rdData;
        monAddr = 3'd7; #0.1; l = rdData;
        monAddr = 3'd1; #0.1; s = rdData;
        monBusy = 1'b0;
        chk(e.req, "interrupt cycle", 16'(cyc), 16'(e.cyc));
        chk(e.req, "cause flag", {15'd0, s[0]}, {15'd0, e.flag});
        chk(e.req, "capture register", {h, l}, e.capt);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int c0;
    logic [7:0] b;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd8(3'(a), b);
      chk("R1", "register after reset", {8'd0, b}, 16'h0000);
    end
    chk("R1", "irq after reset", {15'd0, irq}, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);

    // T1: rising capture, no prescale (R3)
    setup(16'h0010, 16'hFFFF, 16'h0000);
    wr(3'd0, 8'hC0);
    c0 = cyc;
    expectIrq(c0 + 3, 1'b1, 16'h0012, "R3");
    timerIn = 1'b1;
    repeat (5) @(negedge clk);
    timerIn = 1'b0;              // falling edge must be ignored (R4)
    repeat (7) @(negedge clk);
    wr(3'd0, 8'h00);
    rd16(3'd2, v);
    chk("R4", "count after ignored falling edge", v, 16'h000B);

    // R9 register access
    wr(3'd1, 8'h00);
    rd8(3'd1, b);
    chk("R9", "flag is read-only", {8'd0, b}, 16'h0001);
    wr(3'd6, 8'h12); wr(3'd7, 8'h34);
    rd16(3'd6, v);
    chk("R9", "capture register write", v, 16'h1234);
    wr(3'd0, 8'h45);
    rd8(3'd0, b);
    chk("R9", "control readback", {8'd0, b}, 16'h0045);
    wr(3'd4, 8'hAB); wr(3'd5, 8'hCD);
    rd16(3'd4, v);
    chk("R9", "reload readback", v, 16'hABCD);

    // T2: reload periodic, no prescale (R6)
    setup(16'h0001, 16'h0005, 16'h0000);
    wr(3'd0, 8'h80);
    c0 = cyc;
    expectIrq(c0 + 5, 1'b0, 16'h0000, "R6");
    expectIrq(c0 + 10, 1'b0, 16'h0000, "R6");
    repeat (11) @(negedge clk);
    wr(3'd0, 8'h00);

    // T3: reload with divide-by-four (R2)
    setup(16'h0001, 16'h0003, 16'h0000);
    wr(3'd0, 8'h82);
    c0 = cyc;
    expectIrq(c0 + 12, 1'b0, 16'h0000, "R2");
    expectIrq(c0 + 24, 1'b0, 16'h0000, "R2");
    repeat (26) @(negedge clk);
    wr(3'd0, 8'h00);

    // rising edge while disabled (R8)
    timerIn = 1'b1;
    repeat (6) @(negedge clk);
    rd16(3'd6, v);
    chk("R8", "capture untouched while disabled", v, 16'h0000);
    rd8(3'd1, b);
    chk("R8", "flag untouched while disabled", {8'd0, b}, 16'h0000);

    // T4: falling captures with divide-by-four (R4, R2)
    setup(16'h0100, 16'hFFFF, 16'h0000);
    wr(3'd0, 8'h82);
    c0 = cyc;
    expectIrq(c0 + 3, 1'b1, 16'h0100, "R4");
    expectIrq(c0 + 13, 1'b1, 16'h0003, "R2");
    timerIn = 1'b0;
    repeat (5) @(negedge clk);
    timerIn = 1'b1;
    repeat (5) @(negedge clk);
    timerIn = 1'b0;
    repeat (6) @(negedge clk);
    wr(3'd0, 8'h00);

    // T5: capture coincides with reload match (R7)
    setup(16'h0001, 16'h0004, 16'h0000);
    wr(3'd0, 8'hC0);
    c0 = cyc;
    expectIrq(c0 + 4, 1'b1, 16'h0004, "R7");
    expectIrq(c0 + 8, 1'b0, 16'h0004, "R7");
    @(negedge clk);
    timerIn = 1'b1;
    repeat (8) @(negedge clk);
    wr(3'd0, 8'h00);

    // disabled: count frozen, edges ignored (R8)
    rd16(3'd2, v);
    chk("R8", "count at disable", v, 16'h0003);
    timerIn = 1'b0;
    repeat (4) @(negedge clk);
    timerIn = 1'b1;
    repeat (4) @(negedge clk);
    timerIn = 1'b0;
    repeat (10) @(negedge clk);
    rd16(3'd2, v);
    chk("R8", "count held while disabled", v, 16'h0003);
    rd8(3'd1, b);
    chk("R8", "flag held while disabled", {8'd0, b}, 16'h0000);

    repeat (5) @(negedge clk);
    chk("R5", "expected interrupts left unseen", 16'(expQ.size()), 16'h0000);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule